// File: doc/BRIEF.md
# DMA Channel Enable and Request Front End

This block is the control front end of a single DMA channel. Software enables the channel through a control write. Every write that sets the enable bit loads the channel's working state: the forward address pointer and the transfer counter. This also happens when the bit is already set. Transfer requests come from a software trigger or from the rising edge of one selected peripheral interrupt flag. They are latched in a request-status flag, and that flag records a request whether or not the channel is enabled.

When the channel is enabled, idle and has a latched request, the block clears the status flag and issues a one-cycle transfer-start strobe. It then waits for the transfer-done handshake before it consumes another request. Address stepping, bus mastering and the data movement itself belong to the blocks behind it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the enable readback, the request-status flag, the transfer-start strobe, the pointer and the counter are all 0.
- R2: A control write with the enable bit at 1 sets the enable readback and loads the counter from `cnt_reload` in the next cycle. The same happens when the channel is already enabled.
- R3: On such a write, the pointer is loaded from `src_addr` if the source-forward bit is 1, and otherwise from `dst_addr` if the destination-forward bit is 1. With both bits at 0 the pointer keeps its value. At the default setting the source wins when both bits are 1.
- R4: In software mode (`sel_mode` = 0), a select write with `sel_trig` = 1 sets the request-status flag in the next cycle, even when the channel is disabled. A disabled channel never strobes `xfer_start`.
- R5: In peripheral mode (`sel_mode` = 1), a 0-to-1 change of `irq[sel_idx]` sets the flag in the next cycle. Flags that are not selected, and a selected flag held high, set nothing.
- R6: A select write re-arms the edge detector. If the newly selected flag is already 1, the status flag is set two cycles after the write cycle and not one.
- R7: A control write with `ctl_stat` = 1 leaves the status flag unchanged. A write with `ctl_stat` = 0 clears it in the next cycle.
- R8: A request raised in the same cycle as a clearing write wins, and the flag stays 1.
- R9: An enabled, idle channel with the flag set clears the flag and raises `xfer_start` for exactly one cycle. If a request is pending at the enable write, the strobe appears in the third cycle after that write, once the reload cycle has passed.
- R10: After a strobe, no further strobe is issued until `xfer_done` has been seen. A request pending at `xfer_done` strobes two cycles after it.
- R11: In peripheral mode `sel_trig` raises no request. In software mode peripheral flag edges raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable bit written; 1 also reloads |
| ctl_stat | input | 1 | Status bit written; only 0 acts |
| ctl_src_fwd | input | 1 | Source direction is forward |
| ctl_dst_fwd | input | 1 | Destination direction is forward |
| sel_we | input | 1 | Request-select register write strobe |
| sel_mode | input | 1 | 0 software trigger, 1 peripheral |
| sel_idx | input | SEL_W | Index of the peripheral flag |
| sel_trig | input | 1 | Software trigger bit written |
| src_addr | input | ADDR_W | Source address register value |
| dst_addr | input | ADDR_W | Destination address register value |
| cnt_reload | input | CNT_W | Counter reload register value |
| irq | input | NUM_PERIPH | Peripheral interrupt-request flags |
| xfer_done | input | 1 | Current transfer has finished |
| ch_en | output | 1 | Enable bit readback |
| req_stat | output | 1 | Request-status flag readback |
| xfer_start | output | 1 | One-cycle transfer-start strobe |
| fwd_ptr | output | ADDR_W | Loaded forward address pointer |
| xfer_cnt | output | CNT_W | Loaded transfer counter |

## Verification
The bench builds the block with four peripheral flags, so the select index is two bits wide, a 16-bit pointer and a 12-bit counter, and it keeps source priority for the pointer. Four flags are enough to drive a selected and an unselected flag at once, and to move the selection onto a flag that is already high, which triggers the deliberate side-effect set. The narrow counter and the distinct address values make each source of a reload visible. The bench also exercises a request colliding with a clearing write, a request pending at enable, and a request held back until the done handshake.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic {
      REQ_SOFT   = 1'b0,
      REQ_PERIPH = 1'b1
   } req_mode_e;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect
   import dma_chan_pkg::*;
#(
   parameter int NUM_PERIPH = 8,
   parameter int SEL_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PERIPH-1:0] irq,
   input  logic                  sel_we,
   input  logic                  sel_mode,
   input  logic [SEL_W-1:0]      sel_idx,
   input  logic                  sel_trig,
   output logic                  req
);
   logic [SEL_W-1:0] sel_q;
   req_mode_e        mode_q;
   logic             prev_q;
   logic             flag;
   logic             soft_req;
   logic             periph_req;

   generate
      if (NUM_PERIPH == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel_q;
         assign flag = irq[0];
      end else begin : g_mux
         assign flag = irq[sel_q];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         mode_q <= REQ_SOFT;
         prev_q <= 1'b0;
      end else if (sel_we) begin
         sel_q  <= sel_idx;
         mode_q <= req_mode_e'(sel_mode);
         prev_q <= 1'b0;           // re-arm: a flag already high reads as an edge
      end else begin
         prev_q <= flag;
      end
   end

   assign soft_req   = sel_we && sel_trig && (req_mode_e'(sel_mode) == REQ_SOFT);
   assign periph_req = (mode_q == REQ_PERIPH) && flag && !prev_q;
   assign req        = soft_req || periph_req;

   AST_HELD_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_we && !$past(sel_we) && mode_q == REQ_PERIPH && flag && $past(flag)
       && !(sel_we && sel_trig)) |-> !req) else $error("held flag re-requested"); // R5
endmodule

// File: rtl/dma_req_status.sv
module dma_req_status (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic launch,
   input  logic ctl_we,
   input  logic ctl_stat,
   output logic stat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  stat_q <= 1'b0;
      else if (req)                stat_q <= 1'b1;   // a request beats any clear
      else if (launch)             stat_q <= 1'b0;
      else if (ctl_we && !ctl_stat) stat_q <= 1'b0;
   end

   AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> stat_q) else $error("request lost"); // R8
   AST_WRITE1_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_stat && !req && !launch) |=> stat_q == $past(stat_q))
      else $error("write of 1 changed status"); // R7
endmodule

// File: rtl/dma_reload.sv
module dma_reload #(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 16,
   parameter bit SRC_PRIO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ctl_en,
   input  logic              ctl_src_fwd,
   input  logic              ctl_dst_fwd,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [CNT_W-1:0]  cnt_reload,
   output logic              en_q,
   output logic              reload_q,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [CNT_W-1:0]  cnt_q
);
   logic              ptr_load;
   logic [ADDR_W-1:0] ptr_next;
   logic              do_reload;

   assign do_reload = ctl_we && ctl_en;

   generate
      if (SRC_PRIO) begin : g_src_first
         assign ptr_next = ctl_src_fwd ? src_addr : dst_addr;
      end else begin : g_dst_first
         assign ptr_next = ctl_dst_fwd ? dst_addr : src_addr;
      end
   endgenerate
   assign ptr_load = ctl_src_fwd || ctl_dst_fwd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         reload_q <= 1'b0;
         ptr_q    <= '0;
         cnt_q    <= '0;
      end else begin
         reload_q <= do_reload;
         if (ctl_we) en_q <= ctl_en;
         if (do_reload) begin
            cnt_q <= cnt_reload;
            if (ptr_load) ptr_q <= ptr_next;
         end
      end
   end

   AST_RELOAD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      do_reload |=> cnt_q == $past(cnt_reload)) else $error("counter not reloaded"); // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !do_reload |=> $stable(ptr_q)) else $error("pointer moved without reload"); // R3
endmodule

// File: rtl/dma_launch.sv
module dma_launch (
   input  logic clk,
   input  logic rst_n,
   input  logic en_q,
   input  logic stat_q,
   input  logic reload_q,
   input  logic ctl_we,
   input  logic xfer_done,
   output logic launch,
   output logic start_q
);
   logic busy_q;

   assign launch = en_q && stat_q && !busy_q && !reload_q && !ctl_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= launch;
         if (launch)         busy_q <= 1'b1;
         else if (xfer_done) busy_q <= 1'b0;
      end
   end

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q) else $error("start strobe longer than one cycle"); // R9
   AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q && !xfer_done) |=> !start_q) else $error("start without done"); // R10
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
   parameter int ADDR_W     = 24,
   parameter int CNT_W      = 16,
   parameter int NUM_PERIPH = 8,
   parameter bit SRC_PRIO   = 1'b1,
   localparam int SEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_we,
   input  logic                  ctl_en,
   input  logic                  ctl_stat,
   input  logic                  ctl_src_fwd,
   input  logic                  ctl_dst_fwd,
   input  logic                  sel_we,
   input  logic                  sel_mode,
   input  logic [SEL_W-1:0]      sel_idx,
   input  logic                  sel_trig,
   input  logic [ADDR_W-1:0]     src_addr,
   input  logic [ADDR_W-1:0]     dst_addr,
   input  logic [CNT_W-1:0]      cnt_reload,
   input  logic [NUM_PERIPH-1:0] irq,
   input  logic                  xfer_done,
   output logic                  ch_en,
   output logic                  req_stat,
   output logic                  xfer_start,
   output logic [ADDR_W-1:0]     fwd_ptr,
   output logic [CNT_W-1:0]      xfer_cnt
);
   generate
      if (ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("ADDR_W and CNT_W must be at least 1");
      end
      if (NUM_PERIPH < 1 || (NUM_PERIPH & (NUM_PERIPH - 1)) != 0) begin : g_bad_periph
         $error("NUM_PERIPH must be a power of two");
      end
   endgenerate

   logic req;
   logic launch;
   logic reload_q;

   dma_req_detect #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) i_detect (
      .clk(clk), .rst_n(rst_n), .irq(irq), .sel_we(sel_we), .sel_mode(sel_mode),
      .sel_idx(sel_idx), .sel_trig(sel_trig), .req(req)
   );

   dma_req_status i_status (
      .clk(clk), .rst_n(rst_n), .req(req), .launch(launch),
      .ctl_we(ctl_we), .ctl_stat(ctl_stat), .stat_q(req_stat)
   );

   dma_reload #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRC_PRIO(SRC_PRIO)) i_reload (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en),
      .ctl_src_fwd(ctl_src_fwd), .ctl_dst_fwd(ctl_dst_fwd),
      .src_addr(src_addr), .dst_addr(dst_addr), .cnt_reload(cnt_reload),
      .en_q(ch_en), .reload_q(reload_q), .ptr_q(fwd_ptr), .cnt_q(xfer_cnt)
   );

   dma_launch i_launch (
      .clk(clk), .rst_n(rst_n), .en_q(ch_en), .stat_q(req_stat),
      .reload_q(reload_q), .ctl_we(ctl_we), .xfer_done(xfer_done),
      .launch(launch), .start_q(xfer_start)
   );

   AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> ($past(req_stat) && $past(ch_en))) else $error("start without enabled request"); // R4
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && !$past(req)) |-> !req_stat) else $error("status not cleared at start"); // R9
endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;
   localparam int AW = 16;
   localparam int CW = 12;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_we = 0, ctl_en = 0, ctl_stat = 0, ctl_src_fwd = 0, ctl_dst_fwd = 0;
   logic sel_we = 0, sel_mode = 0, sel_trig = 0;
   logic [1:0] sel_idx = '0;
   logic [AW-1:0] src_addr = '0, dst_addr = '0;
   logic [CW-1:0] cnt_reload = '0;
   logic [NP-1:0] irq = '0;
   logic xfer_done = 0;
   logic ch_en, req_stat, xfer_start;
   logic [AW-1:0] fwd_ptr;
   logic [CW-1:0] xfer_cnt;

   int tests = 0;
   int fails = 0;
   int starts = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dma_chan_ctl #(.ADDR_W(AW), .CNT_W(CW), .NUM_PERIPH(NP)) i_dma_chan_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_stat(ctl_stat),
      .ctl_src_fwd(ctl_src_fwd), .ctl_dst_fwd(ctl_dst_fwd), .sel_we(sel_we),
      .sel_mode(sel_mode), .sel_idx(sel_idx), .sel_trig(sel_trig),
      .src_addr(src_addr), .dst_addr(dst_addr), .cnt_reload(cnt_reload), .irq(irq),
      .xfer_done(xfer_done), .ch_en(ch_en), .req_stat(req_stat), .xfer_start(xfer_start),
      .fwd_ptr(fwd_ptr), .xfer_cnt(xfer_cnt)
   );

   always @(posedge clk) if (rst_n && xfer_start) starts <= starts + 1;

   task automatic check(string req, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_ctl(bit en, bit st, bit sf, bit df);
      ctl_we = 1; ctl_en = en; ctl_stat = st; ctl_src_fwd = sf; ctl_dst_fwd = df;
      tick();
      ctl_we = 0; ctl_en = 0; ctl_stat = 0; ctl_src_fwd = 0; ctl_dst_fwd = 0;
   endtask

   task automatic wr_sel(bit mode, logic [1:0] idx, bit trig);
      sel_we = 1; sel_mode = mode; sel_idx = idx; sel_trig = trig;
      tick();
      sel_we = 0; sel_trig = 0;
   endtask

   task automatic t_reset();
      check("R1", "en", ch_en, 0);
      check("R1", "stat", req_stat, 0);
      check("R1", "start", xfer_start, 0);
      check("R1", "ptr", fwd_ptr, 0);
      check("R1", "cnt", xfer_cnt, 0);
   endtask

   task automatic t_soft_disabled();
      wr_sel(0, 2'd0, 1);
      check("R4", "stat after trigger while disabled", req_stat, 1);
      repeat (3) tick();
      check("R4", "starts while disabled", starts, 0);
   endtask

   task automatic t_stat_write();
      wr_ctl(0, 1, 0, 0);
      check("R7", "stat after write of 1", req_stat, 1);
      wr_ctl(0, 0, 0, 0);
      check("R7", "stat after write of 0", req_stat, 0);
   endtask

   task automatic t_collision();
      ctl_we = 1; ctl_stat = 0; sel_we = 1; sel_mode = 0; sel_idx = 0; sel_trig = 1;
      tick();
      ctl_we = 0; sel_we = 0; sel_trig = 0;
      check("R8", "stat after request with clear", req_stat, 1);
   endtask

   task automatic t_enable_pending();
      src_addr = 16'h1234; dst_addr = 16'h5678; cnt_reload = 12'h0A5;
      wr_ctl(1, 1, 1, 0);
      check("R2", "en after enable", ch_en, 1);
      check("R2", "cnt after enable", xfer_cnt, 12'h0A5);
      check("R3", "ptr from source", fwd_ptr, 16'h1234);
      check("R9", "no start in reload cycle", xfer_start, 0);
      tick();
      check("R9", "no start one cycle later", xfer_start, 0);
      check("R9", "stat still pending", req_stat, 1);
      tick();
      check("R9", "start third cycle", xfer_start, 1);
      check("R9", "stat cleared at start", req_stat, 0);
      tick();
      check("R9", "start one cycle only", xfer_start, 0);
      check("R9", "start count", starts, 1);
   endtask

   task automatic t_wait_done();
      wr_sel(0, 2'd0, 1);
      check("R10", "stat latched while busy", req_stat, 1);
      repeat (3) tick();
      check("R10", "no start before done", starts, 1);
      xfer_done = 1;
      tick();
      xfer_done = 0;
      check("R10", "no start in done cycle", xfer_start, 0);
      tick();
      check("R10", "start after done", xfer_start, 1);
      xfer_done = 1;
      tick();
      xfer_done = 0;
      tick();
      check("R10", "start count", starts, 2);
   endtask

   task automatic t_reenable();
      cnt_reload = 12'h03C; dst_addr = 16'h9ABC;
      wr_ctl(1, 1, 0, 1);
      check("R2", "cnt reload while enabled", xfer_cnt, 12'h03C);
      check("R3", "ptr from destination", fwd_ptr, 16'h9ABC);
      src_addr = 16'h1111; cnt_reload = 12'h777;
      wr_ctl(1, 1, 0, 0);
      check("R3", "ptr held with no forward bit", fwd_ptr, 16'h9ABC);
      check("R2", "cnt reloaded again", xfer_cnt, 12'h777);
      wr_ctl(1, 1, 1, 1);
      check("R3", "source wins when both", fwd_ptr, 16'h1111);
      wr_ctl(0, 1, 0, 0);
      check("R2", "disabled", ch_en, 0);
   endtask

   task automatic t_periph();
      wr_sel(1, 2'd1, 0);
      tick();
      check("R5", "stat idle in peripheral mode", req_stat, 0);
      irq[2] = 1;
      tick();
      check("R5", "unselected flag ignored", req_stat, 0);
      irq[1] = 1;
      tick();
      check("R5", "selected edge sets stat", req_stat, 1);
      wr_ctl(0, 0, 0, 0);
      repeat (2) tick();
      check("R5", "held flag no repeat", req_stat, 0);
      wr_sel(1, 2'd0, 1);
      tick();
      check("R11", "trigger ignored in peripheral mode", req_stat, 0);
   endtask

   task automatic t_spurious();
      wr_sel(1, 2'd2, 0);
      check("R6", "not set one cycle after select", req_stat, 0);
      tick();
      check("R6", "set two cycles after select", req_stat, 1);
      wr_ctl(0, 0, 0, 0);
      check("R6", "cleared", req_stat, 0);
   endtask

   task automatic t_soft_ignores_irq();
      wr_sel(0, 2'd0, 0);
      tick();
      irq[0] = 1;
      tick();
      tick();
      check("R11", "flag edge ignored in software mode", req_stat, 0);
      check("R11", "no extra starts", starts, 2);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      t_soft_disabled();
      t_stat_write();
      t_collision();
      t_enable_pending();
      t_wait_done();
      t_reenable();
      t_periph();
      t_spurious();
      t_soft_ignores_irq();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule